// File: doc/BRIEF.md
# Low-Power Wake-Up Controller

This block watches a group of wake sources while the device sits in a low-power state, such as power-down or sleep. When one of them meets its qualifying condition, the block starts a fixed settling interval. During that interval the embedded controller stays held in power-down. At the end of the interval the block gives a single-cycle wake strobe, and the controller resumes.

The wake sources are:

- Events that wake unconditionally:
  - a change of the card-detect level, in either direction;
  - an overcurrent flag on the card supply;
  - a high level on either of two reset pins.
- A gated event: a falling edge on an active-low external interrupt line. It counts only when both of these are set:
  - the interrupt wake-enable;
  - the controller's own interrupt-enable.
- A more tightly gated event: a falling edge on the serial receive line. It goes through the interrupt path, so it needs the receive wake-enable as well as both interrupt enables.

All asynchronous inputs pass through a two-flop synchronizer before they are used.

The low-power flag comes from the controller and is synchronous to the clock. Every rising edge of this flag re-arms the block: it clears any count in progress. While the flag is low, no new wake sequence can start. The block has no data stream, so every pin is a plain level or strobe.

Top module: `lpw_wake_ctrl`

## Requirements
- R1: While the low-power flag is high, a change of the card-detect level starts a wake sequence. This holds for insertion (0 to 1) and for removal (1 to 0).
- R2: While the low-power flag is high, a high supply-overcurrent flag starts a wake sequence.
- R3: While the low-power flag is high, a high level on the card reset pin starts a wake sequence. A high level on the system reset pin does the same.
- R4: A falling edge on the active-low interrupt line starts a wake sequence only when the interrupt wake-enable and the controller interrupt-enable are both 1. With either of them at 0, the edge is ignored.
- R5: A falling edge on the receive line starts a wake sequence only when three enables are all 1: receive wake-enable, interrupt wake-enable and controller interrupt-enable. With any of them at 0, the edge is ignored.
- R6: A qualifying input change made before clock edge k raises `settle_o` after edge k+2. `settle_o` then stays high for exactly SETTLE_CYCLES cycles (default 1536). After that, `wake_o` is high for exactly one cycle while `settle_o` is low.
- R7: Once a settling count has started, further wake sources neither restart it nor shorten it.
- R8: A rising edge of the low-power flag clears any count in progress (`settle_o` goes low after that edge). A new qualifying event then starts a full count again.
- R9: While the low-power flag is low, wake sources start no sequence.
- R10: After reset, `settle_o` and `wake_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp_mode_i | input | 1 | High while the device is in a low-power mode; its rising edge re-arms the block |
| card_present_i | input | 1 | Card-detect level (asynchronous) |
| supply_ovc_i | input | 1 | Card supply overcurrent flag (asynchronous) |
| card_rst_pin_i | input | 1 | Card reset pin level (asynchronous) |
| sys_rst_pin_i | input | 1 | System reset pin level (asynchronous) |
| rx_i | input | 1 | Serial receive line, idle high (asynchronous) |
| ext_irq_n_i | input | 1 | External interrupt line, active low (asynchronous) |
| rx_wake_en_i | input | 1 | Enables wake-up from a receive falling edge |
| irq_wake_en_i | input | 1 | Enables wake-up from the interrupt path |
| ctrl_irq_en_i | input | 1 | Controller's own interrupt-enable |
| settle_o | output | 1 | High while the settling count runs; the controller stays in power-down |
| wake_o | output | 1 | One-cycle strobe when the count ends |

## Verification
The bench targets the enable gating on the two edge-driven paths:
- A receive edge is tried with each of its three enables cleared in turn. A design that skipped the interrupt enables would wake on serial traffic that it should ignore.
- The interrupt line is also tried with each of its two enables cleared.

Card removal is checked as well as card insertion. A detector that looked only for a rising edge of the card level would miss removal.

The settling window is timed to the exact cycle at both of its ends. A second source is fired in the middle of the count: an off-by-one count, or a count that restarted, would move the strobe. Low-power re-entry in the middle of a count is checked, and so is a level held during run mode. A design that cleared the count late, or qualified sources outside low power, would raise `settle_o` when it should stay low.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
  // bit positions inside the synchronized source vector
  localparam int IX_CARD = 0;
  localparam int IX_OVC  = 1;
  localparam int IX_CRST = 2;
  localparam int IX_SRST = 3;
  localparam int IX_RX   = 4;
  localparam int IX_IRQ  = 5;
  localparam int NSRC    = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_DONE  = 2'd2
  } settle_st_e;
endpackage

// File: rtl/lpw_sync.sv
module lpw_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] fall_o,
  output logic [W-1:0] chg_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[i] <= RST_VAL[i];
        s2_q[i] <= RST_VAL[i];
        s3_q[i] <= RST_VAL[i];
      end else begin
        s1_q[i] <= din_i[i];
        s2_q[i] <= s1_q[i];
        s3_q[i] <= s2_q[i];
      end
    end

    assign lvl_o[i]  = s2_q[i];
    assign fall_o[i] = s3_q[i] & ~s2_q[i];
    assign chg_o[i]  = s3_q[i] ^ s2_q[i];

    // A falling edge cannot be seen on two consecutive cycles (R4, R5)
    p_fall_single_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      fall_o[i] |=> !fall_o[i]);
  end
endmodule

// File: rtl/lpw_qualify.sv
module lpw_qualify
  import lpw_pkg::*;
(
  input  logic            rx_wake_en_i,
  input  logic            irq_wake_en_i,
  input  logic            ctrl_irq_en_i,
  input  logic [NSRC-1:0] lvl_i,
  input  logic [NSRC-1:0] fall_i,
  input  logic [NSRC-1:0] chg_i,
  output logic            wake_evt_o
);
  logic card_evt, level_evt, irq_path_open, irq_evt, rx_evt;
  logic unused_bits;

  assign card_evt      = chg_i[IX_CARD];
  assign level_evt     = lvl_i[IX_OVC] | lvl_i[IX_CRST] | lvl_i[IX_SRST];
  assign irq_path_open = irq_wake_en_i & ctrl_irq_en_i;
  assign irq_evt       = fall_i[IX_IRQ] & irq_path_open;
  // the receive line is routed through the interrupt path
  assign rx_evt        = fall_i[IX_RX] & rx_wake_en_i & irq_path_open;

  assign wake_evt_o = card_evt | level_evt | irq_evt | rx_evt;

  assign unused_bits = ^{lvl_i[IX_CARD], lvl_i[IX_RX], lvl_i[IX_IRQ],
                         fall_i[IX_CARD], fall_i[IX_OVC], fall_i[IX_CRST], fall_i[IX_SRST],
                         chg_i[NSRC-1:IX_OVC]};
endmodule

// File: rtl/lpw_settle.sv
module lpw_settle
  import lpw_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_mode_i,
  input  logic wake_evt_i,
  output logic settle_o,
  output logic wake_o
);
  localparam int            CW   = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  settle_st_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lp_q, entry, wake_q, wake_d;

  assign entry = lp_mode_i & ~lp_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    wake_d = 1'b0;
    if (entry) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (lp_mode_i && wake_evt_i) begin
          st_d  = ST_COUNT;
          cnt_d = '0;
        end
        ST_COUNT: if (cnt_q == LAST) begin
          st_d   = ST_DONE;
          wake_d = 1'b1;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
        ST_DONE: st_d = ST_DONE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      lp_q   <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      lp_q   <= lp_mode_i;
      wake_q <= wake_d;
    end
  end

  assign settle_o = (st_q == ST_COUNT);
  assign wake_o   = wake_q;

  p_wake_pulse_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);
  p_cnt_range_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    settle_o |-> (cnt_q <= LAST));
  p_count_step_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (settle_o && cnt_q != LAST && !entry) |=> (settle_o && cnt_q == $past(cnt_q) + CW'(1)));
  p_entry_clear_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> !settle_o && !wake_o);
  p_run_ignore_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !lp_mode_i) |=> !settle_o);
endmodule

// File: rtl/lpw_wake_ctrl.sv
module lpw_wake_ctrl
  import lpw_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_mode_i,
  input  logic card_present_i,
  input  logic supply_ovc_i,
  input  logic card_rst_pin_i,
  input  logic sys_rst_pin_i,
  input  logic rx_i,
  input  logic ext_irq_n_i,
  input  logic rx_wake_en_i,
  input  logic irq_wake_en_i,
  input  logic ctrl_irq_en_i,
  output logic settle_o,
  output logic wake_o
);
  localparam logic [NSRC-1:0] IDLE_LVL = NSRC'((1 << IX_RX) | (1 << IX_IRQ));

  logic [NSRC-1:0] raw, lvl, fall, chg;
  logic            wake_evt;

  always_comb begin
    raw          = '0;
    raw[IX_CARD] = card_present_i;
    raw[IX_OVC]  = supply_ovc_i;
    raw[IX_CRST] = card_rst_pin_i;
    raw[IX_SRST] = sys_rst_pin_i;
    raw[IX_RX]   = rx_i;
    raw[IX_IRQ]  = ext_irq_n_i;
  end

  lpw_sync #(.W(NSRC), .RST_VAL(IDLE_LVL)) u_sync (
    .clk(clk), .rst_n(rst_n), .din_i(raw),
    .lvl_o(lvl), .fall_o(fall), .chg_o(chg)
  );

  lpw_qualify u_qual (
    .rx_wake_en_i(rx_wake_en_i), .irq_wake_en_i(irq_wake_en_i),
    .ctrl_irq_en_i(ctrl_irq_en_i), .lvl_i(lvl), .fall_i(fall), .chg_i(chg),
    .wake_evt_o(wake_evt)
  );

  lpw_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .lp_mode_i(lp_mode_i), .wake_evt_i(wake_evt),
    .settle_o(settle_o), .wake_o(wake_o)
  );

  p_excl_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    !(settle_o && wake_o));
endmodule

// File: tb/tb_lpw_wake_ctrl.sv
`timescale 1ns/1ps
module tb_lpw_wake_ctrl;
  localparam int SETTLE = 1536;
  localparam int NV = 12;
  // {expect, rx_en, irq_en, ctrl_en, card_base, code[2:0]}
  // code: 0 card toggle, 1 overcurrent, 2 card reset pin, 3 system reset pin, 4 irq fall, 5 rx fall
  localparam logic [7:0] VEC [NV] = '{
    8'b1_000_0_000, 8'b1_000_1_000, 8'b1_000_0_001, 8'b1_000_0_010,
    8'b1_000_0_011, 8'b1_011_0_100, 8'b0_001_0_100, 8'b0_010_0_100,
    8'b1_111_0_101, 8'b0_101_0_101, 8'b0_011_0_101, 8'b0_110_0_101
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic lp_mode, card, ovc, crst, srst, rx, irq_n, rx_en, irq_en, ctrl_en;
  logic settle, wake;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  lpw_wake_ctrl #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .lp_mode_i(lp_mode), .card_present_i(card),
    .supply_ovc_i(ovc), .card_rst_pin_i(crst), .sys_rst_pin_i(srst),
    .rx_i(rx), .ext_irq_n_i(irq_n), .rx_wake_en_i(rx_en),
    .irq_wake_en_i(irq_en), .ctrl_irq_en_i(ctrl_en),
    .settle_o(settle), .wake_o(wake)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle_in(input logic cb);
    lp_mode = 1'b0; card = cb; ovc = 1'b0; crst = 1'b0; srst = 1'b0;
    rx = 1'b1; irq_n = 1'b1;
  endtask

  function automatic string req_of(input logic [2:0] c);
    case (c)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic fire(input logic [2:0] c);
    case (c)
      3'd0: card = ~card;
      3'd1: ovc = 1'b1;
      3'd2: crst = 1'b1;
      3'd3: srst = 1'b1;
      3'd4: irq_n = 1'b0;
      default: rx = 1'b0;
    endcase
  endtask

  // after an event driven at a negedge: wait 3 edges, then check the full R6 window
  task automatic expect_window(input string req);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req, settle, 1'b1);
    negs(SETTLE - 1);
    chk("R6", settle, 1'b1);
    chk("R6", wake, 1'b0);
    negs(1);
    chk("R6", settle, 1'b0);
    chk("R6", wake, 1'b1);
    negs(1);
    chk("R6", wake, 1'b0);
  endtask

  task automatic enter_lp(input logic cb);
    @(negedge clk);
    idle_in(cb);
    negs(5);
    lp_mode = 1'b1;
    negs(3);
  endtask

  initial begin
    rx_en = 1'b0; irq_en = 1'b0; ctrl_en = 1'b0;
    idle_in(1'b0);
    negs(3);
    chk("R10", settle, 1'b0);
    chk("R10", wake, 1'b0);
    rst_n = 1'b1;
    negs(3);
    chk("R10", settle, 1'b0);
    chk("R10", wake, 1'b0);

    // table-driven walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] v;
      v = VEC[i];
      rx_en = v[6]; irq_en = v[5]; ctrl_en = v[4];
      enter_lp(v[3]);
      fire(v[2:0]);
      if (v[7]) begin
        expect_window(req_of(v[2:0]));
      end else begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_of(v[2:0]), settle, 1'b0);
        negs(20);
        chk(req_of(v[2:0]), settle, 1'b0);
        chk(req_of(v[2:0]), wake, 1'b0);
      end
    end

    // R9: sources while in run mode start nothing
    rx_en = 1'b1; irq_en = 1'b1; ctrl_en = 1'b1;
    @(negedge clk); idle_in(1'b0);
    negs(5);
    ovc = 1'b1; card = 1'b1; irq_n = 1'b0; rx = 1'b0;
    negs(10);
    chk("R9", settle, 1'b0);
    chk("R9", wake, 1'b0);

    // R7: a second source mid-count leaves the timing unchanged
    enter_lp(1'b1);
    irq_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", settle, 1'b1);
    negs(100);
    ovc = 1'b1; card = 1'b0;
    negs(SETTLE - 1 - 100);
    chk("R7", settle, 1'b1);
    chk("R7", wake, 1'b0);
    negs(1);
    chk("R7", wake, 1'b1);
    negs(1);
    chk("R7", wake, 1'b0);
    chk("R7", settle, 1'b0);

    // R8: re-entry mid-count clears, then a new event gives a full count
    enter_lp(1'b0);
    srst = 1'b1;
    negs(1);
    srst = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8", settle, 1'b1);
    negs(200);
    lp_mode = 1'b0;
    negs(1);
    lp_mode = 1'b1;
    negs(1);
    chk("R8", settle, 1'b0);
    negs(30);
    chk("R8", settle, 1'b0);
    chk("R8", wake, 1'b0);
    crst = 1'b1;
    expect_window("R8");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule